// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the write-only control port of a clock synthesizer. An I2C master writes a fixed frame: the slave address, one throw-away byte, then three bytes that hold the loop divider M (9 bits), the output divider select N (2 bits), an up-spread flag, a down-spread flag and a 6-bit spread amount. The incoming bytes collect in a shadow copy. The active settings take the shadow only when a STOP closes a frame that delivered all three data bytes. A partial or refused frame leaves the active settings as they were.

SCL and SDA are oversampled by the system clock through synchronizer flops. The system clock must run at least four times faster than SCL. The port answers one of two 7-bit addresses, picked by a strap input. A second, parallel path lets strap pins drive M and N directly while an active-low load input is low. The rising edge of that input freezes the pin values. Every update of the active settings raises a single-cycle commit pulse.

Top module: `i2c_divcfg_port`

## Requirements
- R1: After reset the outputs are M = 256 (only bit 8 set), N = 0, up = 0, down = 0, spread = 0, and the port does not pull SDA low.
- R2: The port acknowledges an address byte whose seven address bits are 1,1,0,1,1,S,0 (MSB first), where S is `addr_sel_i`. That is 0x6C with the strap low and 0x6E with it high. Any other address gets no acknowledge.
- R3: An address byte with the direction bit (bit 0) set to 1 is not acknowledged, even when the address matches.
- R4: After the address, the port acknowledges one dummy byte and then three data bytes. Data byte 0 is {N[1:0], M[8:3]}. Data byte 1 bits 7..5 are M[2:0]. Data byte 2 is {up, down, spread[5:0]}.
- R5: Bits 4..0 of data byte 1 have no effect on any output.
- R6: The outputs take the shadow values only on a STOP that follows all three data bytes. A one-cycle pulse on `commit_o` marks the update.
- R7: A frame ended by STOP or by a repeated START before the third data byte changes no output and gives no commit pulse.
- R8: A byte sent after the third data byte is not acknowledged, and its bits do not reach the outputs.
- R9: The acknowledge pulls SDA low only after an SCL falling edge and releases it on the next SCL falling edge.
- R10: While `pload_n_i` is low, M and N follow `m_pin_i` and `n_pin_i` one clock later. Serial commits in that time change nothing.
- R11: On the rising edge of `pload_n_i` the pin values are latched and a commit pulse is raised. M and N then hold until `pload_n_i` goes low again or a serial frame commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock as seen on the bus |
| sda_i | input | 1 | I2C data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| addr_sel_i | input | 1 | Address strap, selects bit 1 of the slave address |
| pload_n_i | input | 1 | Active-low parallel load, latches pins on rising edge |
| m_pin_i | input | 9 | Parallel M divider value |
| n_pin_i | input | 2 | Parallel N select value |
| m_o | output | 9 | Active M divider |
| n_o | output | 2 | Active N select |
| up_o | output | 1 | Active up-spread flag |
| down_o | output | 1 | Active down-spread flag |
| ss_o | output | 6 | Active spread amount |
| commit_o | output | 1 | One-cycle pulse on each active update |

## Verification
The bench aims at frame edges. It sends a fifth byte and checks that the port both refuses it and keeps it out of the outputs; a design that counted bytes loosely would acknowledge it or overwrite the spread field. It cuts frames short with a STOP and with a repeated START; a design that committed on every STOP, or wrote outputs byte by byte, would change M early. It also tests the address strap both ways, a read request, the junk bits of data byte 1, and a serial frame sent while the parallel load is held low. A design with the wrong path priority would let the serial values through, and a design with an edge detector off by one would latch the pin values that follow the load edge instead of those present at it.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int SS_W = 6;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_HIGH = 5'b11011;
  localparam logic [M_W-1:0] M_RESET = 9'd256;

  typedef struct packed {
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
    logic            up;
    logic            dn;
    logic [SS_W-1:0] ss;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{n: '0, m: M_RESET, up: 1'b0, dn: 1'b0, ss: '0};
endpackage

// File: rtl/divcfg_line_sync.sv
module divcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw, cur, prv;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign cur[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= cur;
  end

  assign scl_s   = cur[0];
  assign sda_s   = cur[1];
  assign start_o = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o  = cur[0] & prv[0] & ~prv[1] & cur[1];
  assign rise_o  = cur[0] & ~prv[0];
  assign fall_o  = ~cur[0] & prv[0];
endmodule

// File: rtl/divcfg_frame_rx.sv
module divcfg_frame_rx
  import divcfg_pkg::*;
#(
  parameter int DUMMY_BYTES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_sel,
  input  logic sda_s,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic sda_oe,
  output cfg_t shadow,
  output logic ser_commit
);
  localparam int IDX_B0   = DUMMY_BYTES + 1;
  localparam int IDX_B1   = DUMMY_BYTES + 2;
  localparam int IDX_B2   = DUMMY_BYTES + 3;
  localparam int IDX_W    = $clog2(IDX_B2 + 2);
  localparam int BIT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK} rx_state_t;
  rx_state_t state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              full;
  logic              addr_hit;

  assign addr_hit = (shreg == {ADDR_HIGH, addr_sel, 1'b0, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      full       <= 1'b0;
      sda_oe     <= 1'b0;
      shadow     <= CFG_RESET;
      ser_commit <= 1'b0;
    end else begin
      ser_commit <= 1'b0;
      if (start_det) begin
        state    <= RX_BITS;
        bit_cnt  <= '0;
        byte_idx <= '0;
        full     <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        ser_commit <= full;
        full       <= 1'b0;
        sda_oe     <= 1'b0;
        state      <= RX_IDLE;
      end else begin
        case (state)
          RX_BITS: begin
            if (scl_rise && bit_cnt < BIT_W'(BYTE_W)) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BIT_W'(BYTE_W)) begin
              if (byte_idx == '0) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  state  <= RX_ACK;
                end else begin
                  state  <= RX_IDLE;
                end
              end else if (int'(byte_idx) <= IDX_B2) begin
                sda_oe <= 1'b1;
                state  <= RX_ACK;
                if (int'(byte_idx) == IDX_B0) begin
                  shadow.n       <= shreg[7:6];
                  shadow.m[8:3]  <= shreg[5:0];
                end
                if (int'(byte_idx) == IDX_B1) shadow.m[2:0] <= shreg[7:5];
                if (int'(byte_idx) == IDX_B2) begin
                  shadow.up <= shreg[7];
                  shadow.dn <= shreg[6];
                  shadow.ss <= shreg[5:0];
                  full      <= 1'b1;
                end
              end else begin
                state <= RX_IDLE;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              bit_cnt  <= '0;
              byte_idx <= byte_idx + 1'b1;
              state    <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ser_commit |-> $past(stop_det));
  // R9
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R8
  no_extra_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> int'(byte_idx) <= IDX_B2);
endmodule

// File: rtl/divcfg_active_regs.sv
module divcfg_active_regs
  import divcfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           pload_n,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           ser_commit,
  input  cfg_t           shadow,
  output cfg_t           cfg,
  output logic           commit
);
  logic pload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= CFG_RESET;
      pload_q <= 1'b1;
      commit  <= 1'b0;
    end else begin
      commit  <= 1'b0;
      pload_q <= pload_n;
      if (!pload_n) begin
        cfg.m <= m_pin;
        cfg.n <= n_pin;
      end else if (!pload_q) begin
        cfg.m  <= m_pin;
        cfg.n  <= n_pin;
        commit <= 1'b1;
      end else if (ser_commit) begin
        cfg    <= shadow;
        commit <= 1'b1;
      end
    end
  end

  // R10
  pins_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pload_n)) |-> (cfg.m == $past(m_pin) && cfg.n == $past(n_pin)));
  // R11
  hold_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pload_n) && $past(pload_q) && !$past(ser_commit)) |-> $stable(cfg));
endmodule

// File: rtl/i2c_divcfg_port.sv
module i2c_divcfg_port
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_BYTES = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic            addr_sel_i,
  input  logic            pload_n_i,
  input  logic [M_W-1:0]  m_pin_i,
  input  logic [N_W-1:0]  n_pin_i,
  output logic [M_W-1:0]  m_o,
  output logic [N_W-1:0]  n_o,
  output logic            up_o,
  output logic            down_o,
  output logic [SS_W-1:0] ss_o,
  output logic            commit_o
);
  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic ser_commit;
  cfg_t shadow, cfg;

  divcfg_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_o(start_det), .stop_o(stop_det),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  divcfg_frame_rx #(.DUMMY_BYTES(DUMMY_BYTES)) i_rx (
    .clk(clk), .rst(rst), .addr_sel(addr_sel_i), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_oe(sda_oe_o), .shadow(shadow), .ser_commit(ser_commit)
  );

  divcfg_active_regs i_regs (
    .clk(clk), .rst(rst), .pload_n(pload_n_i), .m_pin(m_pin_i), .n_pin(n_pin_i),
    .ser_commit(ser_commit), .shadow(shadow), .cfg(cfg), .commit(commit_o)
  );

  assign m_o    = cfg.m;
  assign n_o    = cfg.n;
  assign up_o   = cfg.up;
  assign down_o = cfg.dn;
  assign ss_o   = cfg.ss;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe_o && !commit_o));
endmodule

// File: tb/test_i2c_divcfg_port.sv
module test_i2c_divcfg_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, addr_sel = 1'b0, pload_n = 1'b1;
  logic [8:0] m_pin = '0;
  logic [1:0] n_pin = '0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic up_o, down_o, commit_o;
  logic [5:0] ss_o;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0, commits = 0;
  localparam int H = 12;
  logic [18:0] exp_cfg;

  always #2 clk = ~clk;

  i2c_divcfg_port i_i2c_divcfg_port (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pload_n_i(pload_n), .m_pin_i(m_pin), .n_pin_i(n_pin),
    .m_o(m_o), .n_o(n_o), .up_o(up_o), .down_o(down_o), .ss_o(ss_o), .commit_o(commit_o)
  );

  always @(negedge clk) if (commit_o) commits++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] frame_cfg(input logic [7:0] b0, b1, b2);
    return {b0[7:6], b0[5:0], b1[7:5], b2[7], b2[6], b2[5:0]};
  endfunction

  function automatic logic [6:0] slave_addr(input logic sel);
    return {5'b11011, sel, 1'b0};
  endfunction

  task automatic check_cfg(input string req);
    check(req, {13'd0, n_o, m_o, up_o, down_o, ss_o}, {13'd0, exp_cfg});
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H / 2);
    ack = ~sda_bus;
    tick(H / 2); scl_m = 1'b0; tick(H);
  endtask

  // sends address+rw, then nbytes bytes from {dummy,b0,b1,b2,extra}; returns ack bits
  task automatic frame(input logic [6:0] a, input logic rw, input int nbytes,
                       input logic [7:0] b0, b1, b2, input logic do_stop,
                       output logic [5:0] acks);
    logic [7:0] seq [5];
    logic ak;
    seq[0] = {a, rw}; seq[1] = 8'h5A; seq[2] = b0; seq[3] = b1; seq[4] = b2;
    acks = '0;
    i2c_start();
    for (int k = 0; k <= nbytes && k < 5; k++) begin
      send_byte(seq[k], ak); acks[k] = ak;
    end
    if (nbytes >= 5) begin
      send_byte(8'hC3, ak); acks[5] = ak;
    end
    if (do_stop) i2c_stop();
    tick(8);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [5:0] acks;
    logic [7:0] b0, b1, b2;
    int c0;
    void'($urandom(32'd4711));
    tick(4); rst = 1'b0; tick(2);
    exp_cfg = {2'b00, 9'd256, 1'b0, 1'b0, 6'd0};
    check_cfg("R1 reset value");
    check("R1 sda released", {31'd0, sda_oe}, 32'd0);

    // random full frames, both straps, junk low bits of byte1
    for (int it = 0; it < 6; it++) begin
      addr_sel = it[0];
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      c0 = commits;
      frame(slave_addr(addr_sel), 1'b0, 4, b0, b1, b2, 1'b1, acks);
      check("R2 R4 all bytes acked", {26'd0, acks}, 32'h1F);
      exp_cfg = frame_cfg(b0, b1, b2);
      check_cfg("R4 R5 field layout");
      check("R6 one commit pulse", commits - c0, 1);
    end

    // R5: same frame, different junk in byte1 low bits
    b0 = 8'h9C; b2 = 8'h47;
    frame(slave_addr(1'b1), 1'b0, 4, b0, 8'hA0, b2, 1'b1, acks);
    frame(slave_addr(1'b1), 1'b0, 4, b0, 8'hBF, b2, 1'b1, acks);
    exp_cfg = frame_cfg(b0, 8'hA0, b2);
    check_cfg("R5 byte1 low bits ignored");

    // R2 strap mismatch: strap high, address 0x6C
    addr_sel = 1'b1; c0 = commits;
    frame(slave_addr(1'b0), 1'b0, 4, 8'h11, 8'h22, 8'h33, 1'b1, acks);
    check("R2 wrong address nack", {31'd0, acks[0]}, 32'd0);
    check_cfg("R2 wrong address no change");
    check("R2 no commit", commits - c0, 0);

    // R3 read request
    frame(slave_addr(1'b1), 1'b1, 0, 8'h00, 8'h00, 8'h00, 1'b1, acks);
    check("R3 read nack", {31'd0, acks[0]}, 32'd0);

    // R7 abort by STOP after two data bytes
    c0 = commits;
    frame(slave_addr(1'b1), 1'b0, 3, 8'hFF, 8'hE0, 8'hFF, 1'b1, acks);
    check("R7 partial acked", {26'd0, acks}, 32'h0F);
    check_cfg("R7 stop abort no change");
    check("R7 stop abort no commit", commits - c0, 0);

    // R7 abort by repeated START, then complete frame
    frame(slave_addr(1'b1), 1'b0, 2, 8'hFF, 8'hE0, 8'hFF, 1'b0, acks);
    c0 = commits;
    check_cfg("R7 repeated start no change");
    b0 = 8'h4B; b1 = 8'h60; b2 = 8'h83;
    frame(slave_addr(1'b1), 1'b0, 4, b0, b1, b2, 1'b1, acks);
    exp_cfg = frame_cfg(b0, b1, b2);
    check_cfg("R7 frame after repeated start");
    check("R6 commit after restart", commits - c0, 1);

    // R8 extra byte refused
    b0 = 8'h12; b1 = 8'h40; b2 = 8'h05;
    frame(slave_addr(1'b1), 1'b0, 5, b0, b1, b2, 1'b1, acks);
    check("R8 fifth byte nack", {31'd0, acks[5]}, 32'd0);
    check("R9 acks released", {31'd0, sda_oe}, 32'd0);
    exp_cfg = frame_cfg(b0, b1, b2);
    check_cfg("R8 extra byte ignored");

    // R10 parallel follow
    m_pin = 9'h0A5; n_pin = 2'd3; pload_n = 1'b0; tick(2);
    exp_cfg[18:8] = {2'd3, 9'h0A5};
    check_cfg("R10 pins followed");
    m_pin = 9'h133; n_pin = 2'd1; tick(2);
    exp_cfg[18:8] = {2'd1, 9'h133};
    check_cfg("R10 pins followed again");
    c0 = commits;
    frame(slave_addr(1'b1), 1'b0, 4, 8'hFF, 8'hFF, 8'hFF, 1'b1, acks);
    check_cfg("R10 serial ignored while low");
    check("R10 no commit while low", commits - c0, 0);

    // R11 latch on rising edge
    m_pin = 9'h0F0; n_pin = 2'd2; c0 = commits;
    pload_n = 1'b1; tick(1);
    m_pin = 9'h00F; n_pin = 2'd0; tick(3);
    exp_cfg[18:8] = {2'd2, 9'h0F0};
    check_cfg("R11 latched value held");
    check("R11 load commit pulse", commits - c0, 1);
    b0 = 8'hC8; b1 = 8'h20; b2 = 8'h41;
    frame(slave_addr(1'b1), 1'b0, 4, b0, b1, b2, 1'b1, acks);
    exp_cfg = frame_cfg(b0, b1, b2);
    check_cfg("R11 serial overrides latch");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule